// File: doc/BRIEF.md
# Delayed-Parity Checker with Stretched Error Flag

This block checks even parity over the command and address bits of a registered buffer, where the parity bit for a word reaches the block one clock after the word itself. The block reduces the checked bits of each word, delays that partial result so it lines up with the late parity bit, and registers the combined value as a partial-parity output. If the combined value is non-zero, the block drives an active-low error flag. The flag is held low for a fixed number of cycles. A low-power input freezes the flag.

Two copies can be chained to cover a wider bus. The lead copy folds the external parity bit into its own bits and passes the result on through its partial-parity output, while keeping its own flag quiet. The tail copy takes that output as its parity input, adds an extra alignment delay to its own bits, and reports the combined error. Control-type bits of the word (clock enable, termination and the chip selects) occupy fixed lanes and are left out of the check.

Top module: `dly_parity_chk`

## Requirements
- R1: The checked bits are `data_i[20:0]`. `par_i` sampled at clock edge n+1 belongs to the word sampled at edge n, and the check is even: a word is good when the XOR of its checked bits and its parity bit is 0.
- R2: In solo mode (`pair_i`=0), the word sampled at edge n and the parity bit sampled at edge n+1 set `ppo_o` to their XOR at edge n+2. `err_no` goes low at that same edge when the XOR is 1.
- R3: After a mismatch, `err_no` stays low for exactly 2 cycles. A further mismatch inside that window restarts the 2-cycle count.
- R4: While `rst_ni` is low, `err_no` is 1 and `ppo_o` is 0, independent of the clock. Asserting reset ends a stretch in progress.
- R5: Lanes `data_i[24:21]` (clock enable, termination and the two chip selects) have no effect on `ppo_o` or `err_no`.
- R6: While `lp_i` is high at an edge, `err_no` keeps its value and its stretch count is frozen. A mismatch seen at such an edge is dropped. `ppo_o` keeps updating.
- R7: In lead mode (`pair_i`=1, `upper_i`=0), `ppo_o` follows the solo timing of R2 and `err_no` stays at 1.
- R8: In tail mode (`pair_i`=1, `upper_i`=1), with `par_i` driven by the lead copy's `ppo_o`, the word sampled at edge n produces the combined XOR on `ppo_o` and the error at edge n+4.
- R9: With `pair_i`=0, the block behaves as in solo mode whatever the value of `upper_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W (25) | Registered word; bits [24:21] are control lanes |
| par_i | input | 1 | Parity bit, one cycle after its word (tail mode: lead's ppo_o) |
| pair_i | input | 1 | 0: solo, 1: paired; static between resets |
| upper_i | input | 1 | Paired only: 0 lead, 1 tail; static between resets |
| lp_i | input | 1 | Low-power flag; freezes err_no while high |
| ppo_o | output | 1 | Registered partial-parity result |
| err_no | output | 1 | Stretched error flag, active low |

## Verification
A new mismatch can reach the stretch counter at the same edge as another event: the counter is still draining an earlier error, the low-power flag is high, or reset is asserted. The bench provokes each case. Random injection is mixed with directed patterns that flip parity on back-to-back words, raise the low-power flag on the edge where a mismatch lands, and assert reset while the flag is low. The bench checks the counter value it expects at each edge against `err_no` to confirm the restart, the dropped mismatch and the forced release. In paired runs, an error injected in either copy's bits must appear only on the tail copy's flag, four edges after the word.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    MODE_SOLO = 2'd0,
    MODE_LEAD = 2'd1,
    MODE_TAIL = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(logic pair, logic upper);
    if (!pair) return MODE_SOLO;
    return upper ? MODE_TAIL : MODE_LEAD;
  endfunction
endpackage

// File: rtl/masked_xor.sv
module masked_xor #(
  parameter int               W    = 25,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic [W-1:0] data_i,
  output logic         par_o
);
  assign par_o = ^(data_i & MASK);
endmodule

// File: rtl/parity_delay.sv
module parity_delay #(
  parameter int MAX_DEPTH = 3,
  localparam int TW = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          d_i,
  input  logic [TW-1:0] tap_i,
  output logic          q_o
);
  logic [MAX_DEPTH-1:0] stg_q;

  generate
    if (MAX_DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[MAX_DEPTH-2:0], d_i};
    end
  endgenerate

  // tap k = k+1 cycles of delay; out-of-range taps pick the last stage
  always_comb begin
    q_o = stg_q[MAX_DEPTH-1];
    for (int i = 0; i < MAX_DEPTH; i++)
      if (TW'(i) == tap_i) q_o = stg_q[i];
  end
endmodule

// File: rtl/err_stretch.sv
module err_stretch #(
  parameter int STRETCH = 2,
  localparam int CW = $clog2(STRETCH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic hold_i,
  output logic err_no
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!hold_i) begin
      if (hit_i)            cnt_q <= CW'(STRETCH);
      else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign err_no = (cnt_q == '0);

  AST_ERR_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !hold_i) |=> !err_no); // R3
  AST_ERR_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_no) |=> !err_no); // R3
  AST_ERR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1) && !hit_i && !hold_i) |=> err_no); // R3
  AST_LP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(err_no)); // R6
endmodule

// File: rtl/dly_parity_chk.sv
module dly_parity_chk
  import dpc_pkg::*;
#(
  parameter int               DATA_W     = 25,
  parameter logic [DATA_W-1:0] CHECK_MASK = 25'h01F_FFFF,
  parameter int               STRETCH    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              pair_i,
  input  logic              upper_i,
  input  logic              lp_i,
  output logic              ppo_o,
  output logic              err_no
);
  // tail copy waits two more cycles for the lead's registered ppo
  localparam int TAIL_TAP  = 2;
  localparam int MAX_DEPTH = TAIL_TAP + 1;
  localparam int TAP_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;

  mode_e             mode;
  logic              dp_w, dly_w, hit_w;
  logic              sum_q, ppo_q;
  logic [TAP_W-1:0]  tap_w;

  assign mode  = decode_mode(pair_i, upper_i);
  assign tap_w = (mode == MODE_TAIL) ? TAP_W'(TAIL_TAP) : '0;

  masked_xor #(.W(DATA_W), .MASK(CHECK_MASK)) u_xor (
    .data_i (data_i),
    .par_o  (dp_w)
  );

  parity_delay #(.MAX_DEPTH(MAX_DEPTH)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dp_w),
    .tap_i  (tap_w),
    .q_o    (dly_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= 1'b0;
      ppo_q <= 1'b0;
    end else begin
      sum_q <= dly_w ^ par_i;
      ppo_q <= sum_q;
    end
  end

  assign hit_w = sum_q & (mode != MODE_LEAD);
  assign ppo_o = ppo_q;

  err_stretch #(.STRETCH(STRETCH)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_w),
    .hold_i (lp_i),
    .err_no (err_no)
  );

  // edges since reset release, saturating; gates the $past windows below
  logic [2:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              since_q <= '0;
    else if (since_q != 3'd5) since_q <= since_q + 3'd1;

  AST_RST_OUTS: assert property (@(posedge clk_i)
    !rst_ni |-> (err_no && !ppo_o)); // R4
  AST_LEAD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_LEAD) |-> err_no); // R7
  AST_PPO_SOLO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 3'd3 && mode != MODE_TAIL) |->
      ppo_o == ($past(dp_w, 3) ^ $past(par_i, 2))); // R2
  AST_PPO_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q == 3'd5 && mode == MODE_TAIL) |->
      ppo_o == ($past(dp_w, 5) ^ $past(par_i, 2))); // R8
endmodule

// File: tb/tb_dly_parity_chk.sv
module tb_dly_parity_chk;
  localparam int W = 25;
  localparam logic [W-1:0] MASK = 25'h01F_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] d_lo = '0, d_hi = '0;
  logic par = 1'b0, lp_lo = 1'b0, lp_hi = 1'b0, pair = 1'b0, upper = 1'b0;
  logic ppo_lo, err_lo, ppo_hi, err_hi;

  dly_parity_chk dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d_lo), .par_i(par),
    .pair_i(pair), .upper_i(upper), .lp_i(lp_lo),
    .ppo_o(ppo_lo), .err_no(err_lo)
  );

  dly_parity_chk dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d_hi), .par_i(ppo_lo),
    .pair_i(1'b1), .upper_i(1'b1), .lp_i(lp_hi),
    .ppo_o(ppo_hi), .err_no(err_hi)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit dplo [0:1023];
  bit dphi [0:1023];
  bit pv   [0:1023];
  int c = 0, cnt_lo = 0, cnt_hi = 0;
  bit pair_m = 1'b0;

  function automatic bit g_lo(int i); return (i < 0) ? 1'b0 : dplo[i]; endfunction
  function automatic bit g_hi(int i); return (i < 0) ? 1'b0 : dphi[i]; endfunction
  function automatic bit g_p(int i);  return (i < 0) ? 1'b0 : pv[i];   endfunction
  // ppo after edge e: word from e-2, parity from e-1 (R1, R2)
  function automatic bit e_lo(int e); return g_lo(e-2) ^ g_p(e-1); endfunction
  // tail ppo after edge e: own word from e-4, lead ppo sampled at e-1 (R8)
  function automatic bit e_hi(int e); return g_hi(e-4) ^ e_lo(e-2); endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at step %0d", req, what, act, exp, c);
    end
  endtask

  task automatic do_reset(bit pm, bit up);
    rst_n = 1'b0;
    pair = pm; upper = up;
    d_lo = '0; d_hi = '0; par = 1'b0; lp_lo = 1'b0; lp_hi = 1'b0;
    @(negedge clk);
    check("R4", "err_lo in reset", err_lo, 1'b1);
    check("R4", "ppo_lo in reset", ppo_lo, 1'b0);
    check("R4", "err_hi in reset", err_hi, 1'b1);
    check("R4", "ppo_hi in reset", ppo_hi, 1'b0);
    for (int i = 0; i < 1024; i++) begin dplo[i] = 0; dphi[i] = 0; pv[i] = 0; end
    c = 0; cnt_lo = 0; cnt_hi = 0; pair_m = pm;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(int n, string tag, bit rnd, bit [31:0] inj_pat,
                     bit [31:0] lp_pat, bit ctrl_only);
    bit inj, hit;
    for (int i = 0; i < n; i++) begin
      check(pair_m ? "R7" : "R2", "ppo_lo", ppo_lo, e_lo(c-1));
      check(pair_m ? "R7" : tag, "err_lo", err_lo, cnt_lo == 0);
      if (pair_m) begin
        check("R8", "ppo_hi", ppo_hi, e_hi(c-1));
        check(tag, "err_hi", err_hi, cnt_hi == 0);
      end
      if (ctrl_only) begin
        d_lo = (d_lo & MASK) | (W'($urandom) & ~MASK);
        d_hi = (d_hi & MASK) | (W'($urandom) & ~MASK);
      end else begin
        d_lo = W'($urandom);
        d_hi = W'($urandom);
      end
      inj   = rnd ? ($urandom % 8 == 0) : (i < 32 && inj_pat[i]);
      lp_lo = rnd ? ($urandom % 6 == 0) : (i < 32 && lp_pat[i]);
      lp_hi = rnd ? ($urandom % 6 == 0) : (i < 32 && lp_pat[i]);
      dplo[c] = ^(d_lo & MASK);
      dphi[c] = ^(d_hi & MASK);
      par = (pair_m ? (g_lo(c-1) ^ g_hi(c-1)) : g_lo(c-1)) ^ inj;
      pv[c] = par;
      // stretch model per R3/R6/R7
      hit = pair_m ? 1'b0 : e_lo(c);
      if (!lp_lo) begin
        if (hit) cnt_lo = 2; else if (cnt_lo > 0) cnt_lo--;
      end
      hit = e_hi(c);
      if (!lp_hi) begin
        if (hit) cnt_hi = 2; else if (cnt_hi > 0) cnt_hi--;
      end
      c++;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd5813));
    @(negedge clk);
    do_reset(1'b0, 1'b0);
    run(300, "R3", 1'b1, '0, '0, 1'b0);                         // R1 random solo
    do_reset(1'b0, 1'b0);
    run(24, "R3", 1'b0, 32'h0000_0C04, '0, 1'b0);               // R3 single and back-to-back
    do_reset(1'b0, 1'b0);
    run(24, "R6", 1'b0, 32'h0000_1004, 32'h0000_20F0, 1'b0);    // R6 freeze and dropped hit
    do_reset(1'b0, 1'b0);
    run(40, "R5", 1'b0, '0, '0, 1'b1);                          // R5 control lanes only
    do_reset(1'b0, 1'b1);
    run(100, "R9", 1'b1, '0, '0, 1'b0);                         // R9 upper ignored
    do_reset(1'b1, 1'b0);
    run(400, "R8", 1'b1, '0, '0, 1'b0);                         // R8 random paired
    do_reset(1'b1, 1'b0);
    run(24, "R8", 1'b0, 32'h0000_0404, '0, 1'b0);               // R8 directed paired
    do_reset(1'b0, 1'b0);
    run(5, "R3", 1'b0, 32'h0000_0004, '0, 1'b0);                // error active, then R4
    do_reset(1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule